// File: doc/BRIEF.md
# Page Write Load Controller

This block is the device-side write front end of a byte-wide parallel nonvolatile memory, modelled synchronously. A system clock samples the active-low chip-enable, write-enable and output-enable strobes together with the address and data buses. A write pulse exists while chip-enable and write-enable are both low and output-enable is high. The address is taken when that joint interval begins, and the data from its last sampled cycle. So either strobe can control the write.

The first accepted byte fixes the page, which is the address bits above the six in-page offset bits. Further bytes for the same page go into a 64-entry page buffer that carries a per-byte loaded mask. They may come in any order, and a repeat load of an offset overwrites it. Each accepted byte restarts a byte-load window. When the window lapses, the block enters a programming period of fixed length and shows it on `busy`. At the end of that period it writes only the marked bytes into a register-array model of the memory. During programming, write pulses are ignored and reads return nothing.

The window and programming lengths are parameters in clock cycles. Their defaults are 15000 cycles (150 µs at 100 MHz) and 1,000,000 cycles (10 ms). The address width defaults to 10 bits, which keeps the memory model small. A `writeInhibit` input stands for low supply or the power-on delay, and blocks any write pulse that begins while it is high.

Top module: `page_load_ctrl`

## Requirements
- R1: After reset `busy` is 0, `dataOutEn` is 0 and every memory location reads 0x00.
- R2: A byte is taken only from a pulse in which ceN and weN are both sampled low and oeN high for at least MIN_PULSE cycles. Either the WE-controlled or the CE-controlled order works. The address is the one sampled in the first cycle of the pulse. The data is the one sampled in its last cycle.
- R3: A pulse with fewer than MIN_PULSE low cycles is ignored, and so is a pulse during which oeN is low. A pulse that begins while `writeInhibit` is high is also ignored. None of these starts a load, and the memory is left unchanged.
- R4: `busy` rises WINDOW_CYC+2 clock cycles after the strobe release of the last accepted byte. Each accepted byte restarts this window.
- R5: `busy` stays high for exactly PROG_CYC cycles. The commit to memory happens as `busy` falls.
- R6: Only loaded offsets of the page are written. The other bytes keep their contents. Bytes may be loaded in any order, and the last value loaded for an offset wins.
- R7: During a load, a byte whose address bits above bit 5 differ from the first byte's is ignored. It does not restart the window.
- R8: While `busy` is high, write pulses are ignored and `dataOutEn` stays 0.
- R9: A read is ceN low, oeN low and weN high while not busy. `dataOutEn` goes high and `dataOut` shows the stored byte from the second rising clock edge after the strobes are applied.
- R10: One load period can fill all 64 offsets of a page, and all 64 are committed together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes and buses |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| writeInhibit | input | 1 | High blocks any write pulse that starts while it is high |
| addr | input | ADDR_W | Byte address; the low 6 bits are the in-page offset |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data; 0 when not enabled |
| dataOutEn | output | 1 | High while dataOut carries read data |
| busy | output | 1 | High during the programming period |

## Verification
The hardest case to reach from the ports is a byte from a foreign page that arrives late in a load. Nothing in the memory shows that it was refused, and the only visible effect is that the window was not restarted. The stimulus places such a byte right after the last accepted byte. It then counts clock cycles from the accepted byte's strobe release to the rise of `busy`, and expects no extra delay. Reads of the foreign address after the commit confirm it is still 0x00. A write made during programming and a rewritten byte whose address and data change in the middle of its pulse are each settled the same way, by later reads through the scoreboard.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_PROG} phase_e;

  typedef struct packed {
    logic latchAddr;  // first cycle of a write pulse
    logic trackData;  // write pulse active, follow data bus
    logic storeByte;  // put latched byte into page buffer
    logic setPage;    // first byte of a load fixes the page
    logic commit;     // write marked bytes to the array
  } strobe_t;
endpackage

// File: rtl/pwl_ctrl.sv
module pwl_ctrl
  import pwl_pkg::*;
#(
  parameter int WINDOW_CYC = 15000,
  parameter int PROG_CYC   = 1000000,
  parameter int MIN_PULSE  = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceN,
  input  logic    weN,
  input  logic    oeN,
  input  logic    writeInhibit,
  input  logic    pageMatch,
  output strobe_t strobes,
  output phase_e  phase,
  output logic    busy,
  output logic    readReq
);
  localparam int WIN_W = (WINDOW_CYC > 2) ? $clog2(WINDOW_CYC) : 1;
  localparam int PRG_W = (PROG_CYC > 2) ? $clog2(PROG_CYC) : 1;
  localparam int LEN_W = $clog2(MIN_PULSE + 1) + 1;
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WINDOW_CYC - 1);
  localparam logic [PRG_W-1:0] PRG_LAST = PRG_W'(PROG_CYC - 1);
  localparam logic [LEN_W-1:0] LEN_MIN  = LEN_W'(MIN_PULSE);

  logic sCeN, sWeN, sOeN, sInh;
  logic actPrev, pulseOk;
  logic [LEN_W-1:0] pulseLen;
  logic [WIN_W-1:0] winCnt;
  logic [PRG_W-1:0] progCnt;
  phase_e phaseQ;

  logic wrAct, startEdge, endEdge, byteDone, acceptFirst, acceptMore, progDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sCeN <= 1'b1;
      sWeN <= 1'b1;
      sOeN <= 1'b1;
      sInh <= 1'b1;
    end else begin
      sCeN <= ceN;
      sWeN <= weN;
      sOeN <= oeN;
      sInh <= writeInhibit;
    end
  end

  assign wrAct     = !sCeN && !sWeN && sOeN;
  assign startEdge = wrAct && !actPrev;
  assign endEdge   = !wrAct && actPrev;
  assign byteDone  = endEdge && pulseOk && (pulseLen >= LEN_MIN) && (phaseQ != PH_PROG);
  assign acceptFirst = byteDone && (phaseQ == PH_IDLE);
  assign acceptMore  = byteDone && (phaseQ == PH_LOAD) && pageMatch;
  assign progDone    = (phaseQ == PH_PROG) && (progCnt == PRG_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actPrev  <= 1'b0;
      pulseOk  <= 1'b0;
      pulseLen <= '0;
    end else begin
      actPrev <= wrAct;
      if (startEdge) begin
        pulseLen <= LEN_W'(1);
        pulseOk  <= !sInh && (phaseQ != PH_PROG);
      end else if (wrAct) begin
        if (pulseLen < LEN_MIN) pulseLen <= pulseLen + 1'b1;
        if (phaseQ == PH_PROG) pulseOk <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= PH_IDLE;
      winCnt  <= '0;
      progCnt <= '0;
    end else begin
      unique case (phaseQ)
        PH_IDLE: begin
          if (acceptFirst) begin
            phaseQ <= PH_LOAD;
            winCnt <= '0;
          end
        end
        PH_LOAD: begin
          if (acceptMore) begin
            winCnt <= '0;
          end else if (winCnt == WIN_LAST) begin
            phaseQ  <= PH_PROG;
            progCnt <= '0;
          end else begin
            winCnt <= winCnt + 1'b1;
          end
        end
        PH_PROG: begin
          if (progDone) phaseQ <= PH_IDLE;
          else          progCnt <= progCnt + 1'b1;
        end
        default: phaseQ <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.latchAddr = startEdge;
    strobes.trackData = wrAct;
    strobes.storeByte = acceptFirst || acceptMore;
    strobes.setPage   = acceptFirst;
    strobes.commit    = progDone;
  end

  assign phase   = phaseQ;
  assign busy    = (phaseQ == PH_PROG);
  assign readReq = !sCeN && !sOeN && sWeN && (phaseQ != PH_PROG);
endmodule

// File: rtl/pwl_datapath.sv
module pwl_datapath
  import pwl_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int OFF_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  strobe_t           strobes,
  input  logic              readReq,
  output logic              pageMatch,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int PAGE_W     = ADDR_W - OFF_W;
  localparam int DEPTH      = 1 << ADDR_W;

  logic [ADDR_W-1:0] sAddr, addrLat;
  logic [DATA_W-1:0] sData, dataLat;
  logic [PAGE_W-1:0] pageReg;
  logic [PAGE_BYTES-1:0] loadMask;
  logic [DATA_W-1:0] pageBuf [PAGE_BYTES];
  logic [DATA_W-1:0] mem [DEPTH];
  logic [OFF_W-1:0]  latOff;

  assign latOff    = addrLat[OFF_W-1:0];
  assign pageMatch = (addrLat[ADDR_W-1:OFF_W] == pageReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sAddr   <= '0;
      sData   <= '0;
      addrLat <= '0;
      dataLat <= '0;
      pageReg <= '0;
    end else begin
      sAddr <= addr;
      sData <= dataIn;
      if (strobes.latchAddr) addrLat <= sAddr;
      if (strobes.trackData) dataLat <= sData;
      if (strobes.setPage)   pageReg <= addrLat[ADDR_W-1:OFF_W];
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pageBuf[g]  <= '0;
        loadMask[g] <= 1'b0;
      end else if (strobes.commit) begin
        loadMask[g] <= 1'b0;
      end else if (strobes.storeByte && latOff == OFF_W'(g)) begin
        pageBuf[g]  <= dataLat;
        loadMask[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobes.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (loadMask[i]) mem[{pageReg, OFF_W'(i)}] <= pageBuf[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut   <= '0;
      dataOutEn <= 1'b0;
    end else begin
      dataOutEn <= readReq;
      dataOut   <= readReq ? mem[sAddr] : '0;
    end
  end
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import pwl_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int WINDOW_CYC = 15000,
  parameter int PROG_CYC   = 1000000,
  parameter int MIN_PULSE  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              writeInhibit,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  output logic [7:0]        dataOut,
  output logic              dataOutEn,
  output logic              busy
);
  strobe_t strobes;
  phase_e  phase;
  logic    pageMatch;
  logic    readReq;
  logic    storeByte;

  assign storeByte = strobes.storeByte;

  pwl_ctrl #(
    .WINDOW_CYC(WINDOW_CYC),
    .PROG_CYC  (PROG_CYC),
    .MIN_PULSE (MIN_PULSE)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ceN         (ceN),
    .weN         (weN),
    .oeN         (oeN),
    .writeInhibit(writeInhibit),
    .pageMatch   (pageMatch),
    .strobes     (strobes),
    .phase       (phase),
    .busy        (busy),
    .readReq     (readReq)
  );

  pwl_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(8),
    .OFF_W (6)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .addr     (addr),
    .dataIn   (dataIn),
    .strobes  (strobes),
    .readReq  (readReq),
    .pageMatch(pageMatch),
    .dataOut  (dataOut),
    .dataOutEn(dataOutEn)
  );
endmodule

// File: rtl/pwl_checker.sv
module pwl_checker
  import pwl_pkg::*;
#(
  parameter int PROG_CYC = 1000000
) (
  input logic   clk,
  input logic   rstN,
  input logic   ceN,
  input logic   weN,
  input logic   oeN,
  input logic   busy,
  input logic   dataOutEn,
  input phase_e phase,
  input logic   storeByte,
  input logic   pageMatch
);
  logic [31:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= '0;
    else       busyRun <= busy ? busyRun + 1 : '0;
  end

  // R5: programming never lasts more than PROG_CYC cycles
  a_r5_prog_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < 32'(PROG_CYC)));

  // R8: no read data in the cycle after a busy cycle
  a_r8_no_read_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> !dataOutEn);

  // R9: read data only follows read strobes two edges earlier
  a_r9_read_needs_strobes: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> $past(!ceN && !oeN && weN, 2));

  // R7: a byte stored during a load belongs to the fixed page
  a_r7_same_page: assert property (@(posedge clk) disable iff (!rstN)
    (storeByte && phase == PH_LOAD) |-> pageMatch);

  // R4: programming only follows a load phase
  a_r4_prog_after_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(phase) == PH_LOAD));
endmodule

bind page_load_ctrl pwl_checker #(.PROG_CYC(PROG_CYC)) u_pwl_checker (
  .clk      (clk),
  .rstN     (rstN),
  .ceN      (ceN),
  .weN      (weN),
  .oeN      (oeN),
  .busy     (busy),
  .dataOutEn(dataOutEn),
  .phase    (phase),
  .storeByte(storeByte),
  .pageMatch(pageMatch)
);

// File: tb/test_page_load_ctrl.sv
module test_page_load_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 10;
  localparam int WIN = 40;
  localparam int PRG = 30;
  localparam int MINP = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, writeInhibit = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic dataOutEn, busy;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [7:0] expQ [$];
  string      tagQ [$];
  logic [AW-1:0] adrQ [$];
  logic prevEn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_load_ctrl #(.ADDR_W(AW), .WINDOW_CYC(WIN), .PROG_CYC(PRG), .MIN_PULSE(MINP)) i_page_load_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .writeInhibit(writeInhibit), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: one expected item per read result
  always @(negedge clk) begin
    if (rstN && dataOutEn && !prevEn) begin
      if (expQ.size() == 0) begin
        check(0, "R9 unexpected read data", dataOut, 0);
      end else begin
        logic [7:0] e;
        string t;
        logic [AW-1:0] a;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        a = adrQ.pop_front();
        check(dataOut == e, $sformatf("%s read @%0h", t, a), dataOut, e);
      end
    end
    prevEn <= dataOutEn;
  end

  task automatic writeByte(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    repeat (3) @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic ceWrite(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; weN = 1'b0;
    @(negedge clk); ceN = 1'b0;
    repeat (3) @(negedge clk);
    ceN = 1'b1;
    @(negedge clk); weN = 1'b1;
  endtask

  task automatic morphWrite(input logic [AW-1:0] a1, input logic [7:0] d1,
                            input logic [AW-1:0] a2, input logic [7:0] d2);
    @(negedge clk);
    addr = a1; dataIn = d1; ceN = 1'b0; weN = 1'b0;
    @(negedge clk);
    addr = a2; dataIn = d2;
    repeat (2) @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
  endtask

  task automatic rawPulse(input logic [AW-1:0] a, input logic [7:0] d, input int lowCyc, input bit oeLow);
    @(negedge clk);
    addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0; oeN = oeLow ? 1'b0 : 1'b1;
    repeat (lowCyc) @(negedge clk);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
  endtask

  task automatic readExp(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    expQ.push_back(e); tagQ.push_back(tag); adrQ.push_back(a);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    repeat (3) @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic measureBusy(input int startOff, input string tag);
    int n, m;
    n = startOff;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk); n++;
      if (busy) break;
    end
    check(n == WIN + 2, {tag, " R4 busy rise cycle"}, n, WIN + 2);
    m = 0;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk); m++;
      if (!busy) break;
    end
    check(m == PRG, {tag, " R5 busy length"}, m, PRG);
  endtask

  task automatic watchNoBusy(input int cyc, input string tag);
    bit seen = 0;
    for (int k = 0; k < cyc; k++) begin
      @(negedge clk);
      if (busy) seen = 1;
    end
    check(!seen, {tag, " no load started"}, seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(dataOutEn == 1'b0, "R1 dataOutEn after reset", dataOutEn, 0);
    readExp(10'h000, 8'h00, "R1");
    readExp(10'h3FF, 8'h00, "R1");

    // single byte, window and programming timing
    writeByte(10'h045, 8'hA5);
    measureBusy(0, "single");
    readExp(10'h045, 8'hA5, "R2");
    readExp(10'h044, 8'h00, "R6");

    // page 3: any order, reload, CE-controlled, foreign page byte last
    writeByte(10'h0CA, 8'h11);
    writeByte(10'h0C2, 8'h22);
    writeByte(10'h0CA, 8'h33);
    ceWrite(10'h0C0, 8'h55);
    writeByte(10'h0FF, 8'h44);
    writeByte(10'h200, 8'h99);   // R7 foreign page, must not extend window
    measureBusy(4, "R7");
    readExp(10'h0CA, 8'h33, "R6 reload");
    readExp(10'h0C2, 8'h22, "R6");
    readExp(10'h0FF, 8'h44, "R6");
    readExp(10'h0C0, 8'h55, "R2 ce-controlled");
    readExp(10'h0C1, 8'h00, "R6 untouched");
    readExp(10'h200, 8'h00, "R7 foreign");

    // R2 address from first cycle, data from last cycle
    morphWrite(10'h145, 8'h10, 10'h146, 8'h20);
    measureBusy(0, "R2 morph");
    readExp(10'h145, 8'h20, "R2 addr first data last");
    readExp(10'h146, 8'h00, "R2 later addr unused");

    // R3 ignored pulses
    rawPulse(10'h300, 8'h77, 1, 1'b0);
    watchNoBusy(WIN + 10, "R3 short pulse");
    rawPulse(10'h300, 8'h78, 3, 1'b1);
    watchNoBusy(WIN + 10, "R3 oe low");
    writeInhibit = 1'b1;
    writeByte(10'h300, 8'h79);
    watchNoBusy(WIN + 10, "R3 inhibit");
    writeInhibit = 1'b0;
    readExp(10'h300, 8'h00, "R3 memory unchanged");

    // R8 writes and reads during programming
    writeByte(10'h302, 8'hC3);
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (busy) break;
    end
    writeByte(10'h301, 8'hEE);
    @(negedge clk);
    addr = 10'h302; ceN = 1'b0; oeN = 1'b0;
    begin
      bit en = 0;
      repeat (4) begin
        @(negedge clk);
        if (dataOutEn) en = 1;
      end
      check(!en && busy, "R8 no read data while busy", en, 0);
    end
    ceN = 1'b1; oeN = 1'b1;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
    watchNoBusy(WIN + 10, "R8 write during busy");
    readExp(10'h302, 8'hC3, "R8 first byte kept");
    readExp(10'h301, 8'h00, "R8 busy write dropped");

    // R10 full page
    for (int i = 0; i < 64; i++) writeByte(10'h1C0 + AW'(i), 8'(i) ^ 8'h5A);
    measureBusy(0, "R10");
    for (int i = 0; i < 64; i++) readExp(10'h1C0 + AW'(i), 8'(i) ^ 8'h5A, "R10");
    readExp(10'h200, 8'h00, "R10 next page");

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R9 every read produced data", expQ.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule